// File: doc/BRIEF.md
# Prescaled System Time Base

This block keeps a free-running wide time counter that advances once every `PRESCALE` input clocks. With the default settings (a 34-bit counter, a divide-by-12 prescaler and a 48 MHz clock), one count is 250 ns. Two read views of equal width are taken from the one counter:

- The fine view starts at counter bit 0.
- The coarse view starts at counter bit `COARSE_SHIFT` (default 2), which gives 1 µs per step at the default settings.

A one-cycle overflow pulse marks the point where the counter wraps to zero.

Software reaches three settings through a small write port:

- A one-hot (or multi-hot) selection field. It routes chosen counter bits, starting at bit `SEL_BASE`, onto an event output.
- A halt-control bit. It lets a core-halted input freeze the time base while a debugger holds the core.
- A resynchronisation request.

After reset the counter waits, held at zero, for the first rising edge of a slow low-frequency tick. That edge starts counting and sets the run flag. A later resynchronisation request raises the sync flag again. The next rising edge of the slow tick then restarts the prescaler phase without disturbing the count.

Top module: `systime_base`

## Requirements
- R1: After reset the counter, both views, the overflow pulse and the event output are 0; the sync flag is 1; the run flag is 0; halt control and the selection field are 0.
- R2: The counter stays at 0 until the first rising edge of `lf_tick`. On the clock edge that samples it, the sync flag clears to 0 and the run flag becomes 1 and stays 1 until reset.
- R3: Once running, the counter increments by one every `PRESCALE` advancing clocks. The first increment appears `PRESCALE` clocks after the clock edge that accepted the slow-tick edge.
- R4: `fine_time` equals counter bits `VIEW_W-1:0`, where `VIEW_W = CNT_W - COARSE_SHIFT`.
- R5: `coarse_time` equals counter bits `CNT_W-1:COARSE_SHIFT`.
- R6: `ovf_pulse` is high for exactly the one clock in which the counter reads zero after wrapping from all ones.
- R7: Register address 0 sets the selection field from `reg_wdata[SEL_W-1:0]`. Selection bit k forwards counter bit `SEL_BASE+k`. `time_evt` is the OR of all selected bits, and it is 0 when the field is 0.
- R8: Register address 1, bit 0 is halt control. When it is 1 and `core_halted` is high, the counter and the prescaler phase both hold. Counting resumes from the held phase when `core_halted` falls.
- R9: When halt control is 0, `core_halted` has no effect on counting.
- R10: Any write to register address 2 sets the sync flag to 1 while counting continues. The next rising edge of `lf_tick` clears the flag and restarts the prescaler phase, so the next increment comes `PRESCALE` clocks later. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_halted | input | 1 | Core-halted indication from the debug logic |
| lf_tick | input | 1 | Slow low-frequency tick, already synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 selection, 1 halt control, 2 resync, 3 unused |
| reg_wdata | input | SEL_W | Register write data |
| fine_time | output | VIEW_W | Counter bits VIEW_W-1:0 |
| coarse_time | output | VIEW_W | Counter bits CNT_W-1:COARSE_SHIFT |
| ovf_pulse | output | 1 | One-clock pulse on counter wrap |
| time_evt | output | 1 | OR of the selected counter bits |
| running | output | 1 | Run flag |
| sync_busy | output | 1 | Sync flag, 1 while waiting for a slow-tick edge |

## Verification
The bench builds the block with `CNT_W=10`, `PRESCALE=3`, `SEL_W=8` and `SEL_BASE=2`. A full wrap then takes about three thousand clocks, so the overflow pulse and the wrap of both views are reached many times within a short run. An eight-bit selection window over a ten-bit counter still covers every selectable bit, including the top counter bit, through random selection writes. A divide-by-three prescaler keeps the phase-restart and freeze-with-kept-phase cases short enough to check cycle by cycle against a bench model.

// File: rtl/systime_pkg.sv
package systime_pkg;

    // Register select codes of the write port
    typedef enum logic [1:0] {
        REG_SELECT = 2'd0,
        REG_HALT   = 2'd1,
        REG_RESYNC = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/systime_sync.sv
module systime_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_tick,
    input  logic restart,
    output logic running,
    output logic busy,
    output logic phase_rst
);

    typedef struct packed {
        logic lf_prev;
        logic busy;
        logic run;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic lf_rise;

    always_comb begin
        st_d       = st_q;
        lf_rise    = lf_tick && !st_q.lf_prev;
        phase_rst  = st_q.busy && lf_rise;
        st_d.lf_prev = lf_tick;
        if (phase_rst) begin
            st_d.busy = 1'b0;
            st_d.run  = 1'b1;
        end
        if (restart) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lf_prev <= 1'b0;
            st_q.busy    <= 1'b1;
            st_q.run     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.run;
    assign busy    = st_q.busy;

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lf_tick && !st_q.lf_prev && !restart) |=> (!busy && running)) else $error("sync flag not cleared"); // R2
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running) else $error("run flag dropped"); // R2
    AST_RESYNC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> busy) else $error("resync did not raise flag"); // R10

endmodule

// File: rtl/systime_prescale.sv
module systime_prescale #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic phase_rst,
    output logic step
);

    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = advance && (st_q.phase == LAST) && !phase_rst;
        if (phase_rst) begin
            st_d.phase = '0;
        end else if (advance) begin
            st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= LAST) else $error("prescaler out of range"); // R3
    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !phase_rst) |=> $stable(st_q.phase)) else $error("phase moved while frozen"); // R8
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst |=> (st_q.phase == '0)) else $error("phase not restarted"); // R10

endmodule

// File: rtl/systime_bitsel.sv
module systime_bitsel #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] window,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);

    logic [SEL_W-1:0] hits;

    for (genvar k = 0; k < SEL_W; k++) begin : g_tap
        assign hits[k] = window[k] & sel[k];
    end

    assign evt = |hits;

endmodule

// File: rtl/systime_base.sv
module systime_base #(
    parameter int CNT_W        = 34,
    parameter int PRESCALE     = 12,
    parameter int COARSE_SHIFT = 2,
    parameter int SEL_W        = 16,
    parameter int SEL_BASE     = 2,
    localparam int VIEW_W      = CNT_W - COARSE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_halted,
    input  logic              lf_tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [SEL_W-1:0]  reg_wdata,
    output logic [VIEW_W-1:0] fine_time,
    output logic [VIEW_W-1:0] coarse_time,
    output logic              ovf_pulse,
    output logic              time_evt,
    output logic              running,
    output logic              sync_busy
);
    import systime_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic [SEL_W-1:0] sel;
        logic             halt_en;
    } base_state_t;

    base_state_t st_d, st_q;
    logic     advance;
    logic     step;
    logic     phase_rst;
    logic     restart;
    reg_sel_e wsel;

    assign wsel    = reg_sel_e'(reg_addr);
    assign restart = reg_wr && (wsel == REG_RESYNC);
    assign advance = running && !(st_q.halt_en && core_halted);

    systime_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .lf_tick   (lf_tick),
        .restart   (restart),
        .running   (running),
        .busy      (sync_busy),
        .phase_rst (phase_rst)
    );

    systime_prescale #(.PRESCALE(PRESCALE)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .phase_rst (phase_rst),
        .step      (step)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = step && (st_q.count == CNT_MAX);
        if (step) begin
            st_d.count = st_q.count + 1'b1;
        end
        if (reg_wr) begin
            case (wsel)
                REG_SELECT: st_d.sel     = reg_wdata;
                REG_HALT:   st_d.halt_en = reg_wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count   <= '0;
            st_q.ovf     <= 1'b0;
            st_q.sel     <= '0;
            st_q.halt_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    systime_bitsel #(.SEL_W(SEL_W)) u_bitsel (
        .window (st_q.count[SEL_BASE +: SEL_W]),
        .sel    (st_q.sel),
        .evt    (time_evt)
    );

    assign fine_time   = st_q.count[VIEW_W-1:0];
    assign coarse_time = st_q.count[CNT_W-1 -: VIEW_W];
    assign ovf_pulse   = st_q.ovf;

    AST_IDLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (st_q.count == '0)) else $error("counted before sync"); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st_q.count == CNT_W'($past(st_q.count) + 1'b1))) else $error("bad increment"); // R3
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt_en && core_halted) |=> $stable(st_q.count)) else $error("count moved in halt"); // R8
    AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (st_q.count == '0 && $past(st_q.count) == CNT_MAX)) else $error("stray overflow"); // R6
    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse) else $error("overflow wider than one clock"); // R6

endmodule

// File: tb/sim_systime_base.sv
module sim_systime_base;

    localparam int CNT_W = 10;
    localparam int PRESC = 3;
    localparam int SHIFT = 2;
    localparam int SEL_W = 8;
    localparam int SBASE = 2;
    localparam int VW    = CNT_W - SHIFT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_halted = 1'b0;
    logic lf_tick = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [SEL_W-1:0] reg_wdata = '0;
    logic [VW-1:0] fine_time, coarse_time;
    logic ovf_pulse, time_evt, running, sync_busy;

    int checks = 0;
    int errors = 0;
    int ovf_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    systime_base #(.CNT_W(CNT_W), .PRESCALE(PRESC), .COARSE_SHIFT(SHIFT),
                   .SEL_W(SEL_W), .SEL_BASE(SBASE)) u0 (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .lf_tick(lf_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .fine_time(fine_time), .coarse_time(coarse_time), .ovf_pulse(ovf_pulse),
        .time_evt(time_evt), .running(running), .sync_busy(sync_busy));

    // Reference model, written from the requirements
    logic [CNT_W-1:0] m_cnt;
    int   m_ph;
    bit   m_busy, m_run, m_lfp, m_halt, m_ovf;
    logic [SEL_W-1:0] m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_ph = 0; m_busy = 1; m_run = 0; m_lfp = 0;
            m_halt = 0; m_ovf = 0; m_sel = '0;
        end else begin
            bit edge_ok, prst, adv, stp;
            edge_ok = lf_tick && !m_lfp;
            m_lfp   = lf_tick;
            prst    = m_busy && edge_ok;
            adv     = m_run && !(m_halt && core_halted);
            stp     = adv && (m_ph == PRESC - 1) && !prst;
            if (prst) m_ph = 0;
            else if (adv) m_ph = (m_ph == PRESC - 1) ? 0 : m_ph + 1;
            m_ovf = stp && (m_cnt == {CNT_W{1'b1}});
            if (stp) m_cnt = m_cnt + 1'b1;
            if (prst) begin m_busy = 0; m_run = 1; end
            if (reg_wr) begin
                if (reg_addr == 2'd0) m_sel = reg_wdata;
                if (reg_addr == 2'd1) m_halt = reg_wdata[0];
                if (reg_addr == 2'd2) m_busy = 1;
            end
        end
    end

    function automatic bit exp_evt(logic [CNT_W-1:0] c, logic [SEL_W-1:0] s);
        return |(c[SBASE +: SEL_W] & s);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(fine_time == m_cnt[VW-1:0], "R4", "fine_time", fine_time, m_cnt[VW-1:0]);
        chk(coarse_time == m_cnt[CNT_W-1:SHIFT], "R5", "coarse_time", coarse_time, m_cnt[CNT_W-1:SHIFT]);
        chk(ovf_pulse == m_ovf, "R6", "ovf_pulse", ovf_pulse, m_ovf);
        chk(time_evt == exp_evt(m_cnt, m_sel), "R7", "time_evt", time_evt, exp_evt(m_cnt, m_sel));
        chk(running == m_run, "R2", "running", running, m_run);
        chk(sync_busy == m_busy, "R10", "sync_busy", sync_busy, m_busy);
        if (ovf_pulse) ovf_seen++;
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [1:0] a, logic [SEL_W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    initial begin
        logic [VW-1:0] held;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fine_time == 0 && coarse_time == 0, "R1", "views at reset", fine_time, 0);
        chk(sync_busy == 1'b1, "R1", "sync flag at reset", sync_busy, 1);
        chk(running == 1'b0 && ovf_pulse == 1'b0 && time_evt == 1'b0, "R1", "flags at reset", running, 0);
        // R2 idle before first slow edge
        repeat (8) cyc();
        chk(fine_time == 0, "R2", "no count before sync", fine_time, 0);
        // R2 / R3 first slow-tick edge
        lf_tick = 1'b1;
        cyc();
        chk(running == 1'b1 && sync_busy == 1'b0, "R2", "run after edge", running, 1);
        repeat (PRESC - 1) cyc();
        chk(fine_time == 0, "R3", "no increment before period", fine_time, 0);
        cyc();
        chk(fine_time == 1, "R3", "first increment", fine_time, 1);
        lf_tick = 1'b0;
        // R7 single, multiple, none
        wr(2'd0, 8'h01);
        repeat (6) cyc();
        wr(2'd0, 8'h85);
        repeat (6) cyc();
        wr(2'd0, 8'h00);
        cyc();
        chk(time_evt == 1'b0, "R7", "empty selection", time_evt, 0);
        // R9 halted input ignored with halt control 0
        core_halted = 1'b1;
        held = fine_time;
        repeat (PRESC * 4) cyc();
        chk(fine_time == VW'(held + 4), "R9", "counts while halted ignored", fine_time, VW'(held + 4));
        // R8 freeze
        wr(2'd1, 8'h01);
        held = fine_time;
        repeat (20) cyc();
        chk(fine_time == held, "R8", "frozen count", fine_time, held);
        core_halted = 1'b0;
        repeat (PRESC * 2) cyc();
        chk(fine_time == VW'(held + 2), "R8", "resume keeps phase", fine_time, VW'(held + 2));
        // R10 resync while counting
        wr(2'd2, 8'h00);
        chk(sync_busy == 1'b1, "R10", "resync raises flag", sync_busy, 1);
        repeat (PRESC * 2) cyc();
        lf_tick = 1'b1;
        cyc();
        held = fine_time;
        chk(sync_busy == 1'b0, "R10", "resync done", sync_busy, 0);
        repeat (PRESC - 1) cyc();
        chk(fine_time == held, "R10", "phase restarted", fine_time, held);
        cyc();
        chk(fine_time == VW'(held + 1), "R10", "increment after restart", fine_time, VW'(held + 1));
        lf_tick = 1'b0;
        // Address 3 ignored (R10)
        wr(2'd3, 8'hFF);
        chk(sync_busy == 1'b0 && time_evt == exp_evt(m_cnt, m_sel), "R10", "spare address", sync_busy, 0);
        // Random phase
        for (int i = 0; i < 15000; i++) begin
            if ($urandom_range(39) == 0) lf_tick = ~lf_tick;
            if ($urandom_range(29) == 0) core_halted = ~core_halted;
            if ($urandom_range(49) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 2'($urandom_range(3));
                reg_wdata = SEL_W'($urandom);
            end else begin
                reg_wr = 1'b0;
            end
            cyc();
        end
        reg_wr = 1'b0;
        chk(ovf_seen > 0, "R6", "overflow pulses seen", ovf_seen, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule